// File: doc/BRIEF.md
# Configuration Access Retry Gate

This block guards a bridge's configuration register space while the device powers up. When the fundamental reset is released, a strap input is captured. If the strap was high, the block stays in a local-setup phase. During that phase every configuration request from the upstream host is turned away with a retry-status completion, and no register changes. Meanwhile two local agents can read and write the registers freely. One is a sideband management port. The other carries Type 0 configuration cycles that arrive from the downstream bus.

A local agent ends the phase by writing zero to the in-progress bit of the initialization register. From then on, host requests complete normally against the same register file. The block also drives an active-low configuration-reset output that marks every reset of the configuration space. It drives a secondary-bus reset output from a control bit that software can set. Setting that bit leaves the configuration registers and the configuration-reset output untouched.

Top module: `cfg_retry_gate`

## Requirements
- R1: The strap is captured at the first rising clock edge after `rst_n` is released. Only that capture decides whether setup mode is entered, and later strap changes have no effect. The mode is visible as bit IP_BIT (default 0) of register INIT_IDX (default 0x3F, byte offset FCh), which reads 1 while the mode is active.
- R2: While setup mode is active, `hst_req_ready` is 1. Every host request completes one cycle later with `hst_cpl_status` = 3'b010 (retry) and `hst_cpl_rdata` = 0. A host write changes no register.
- R3: If the strap is low at capture, the in-progress bit reads 0. A host request made in the capture cycle completes one cycle later with status 3'b000 (success).
- R4: Writing 0 to the in-progress bit from the sideband or Type 0 port clears it. Writing 1 from a local port does not set it, and host writes to it have no effect. The other bits of the initialization register are ordinary storage.
- R5: The register file accepts one access per cycle, with fixed priority: sideband, then Type 0, then host. `t0_ready` is low while `sb_valid` is high. Outside setup mode, `hst_req_ready` is low while either local port is valid. Each accepted local access is acknowledged one cycle later.
- R6: Read data appears one cycle after the read is accepted. It reflects every write accepted in an earlier cycle, including a write from a different port in the cycle just before.
- R7: A host request accepted in the same cycle that a local write clears the in-progress bit completes with retry status. Every later host request completes with status 3'b000 and carries real read data.
- R8: `cfg_rst_n_o` is 0 while `rst_n` is low. It goes to 1 at the first clock edge after release and stays at 1 until the next fundamental reset.
- R9: `sec_bus_rst_o` follows bit BCTL_BIT (default 22) of register BCTL_IDX (default 0x0F). Setting that bit changes no other register, no in-progress bit and no `cfg_rst_n_o`.
- R10: After a fundamental reset, every register reads 0, apart from the in-progress bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Fundamental reset, asynchronous, active low |
| strap_cfg_retry | input | 1 | Strap that requests setup mode |
| hst_req_valid | input | 1 | Host configuration request present |
| hst_req_ready | output | 1 | Host request accepted this cycle |
| hst_req_write | input | 1 | Host request is a write |
| hst_req_idx | input | ADDR_W | Host register index (dword) |
| hst_req_wdata | input | DATA_W | Host write data |
| hst_cpl_valid | output | 1 | Host completion valid |
| hst_cpl_status | output | 3 | Completion status: 000 success, 010 retry |
| hst_cpl_rdata | output | DATA_W | Completion read data |
| sb_valid | input | 1 | Sideband access present |
| sb_write | input | 1 | Sideband access is a write |
| sb_idx | input | ADDR_W | Sideband register index |
| sb_wdata | input | DATA_W | Sideband write data |
| sb_ack | output | 1 | Sideband access done |
| sb_rdata | output | DATA_W | Sideband read data |
| t0_valid | input | 1 | Type 0 access present |
| t0_ready | output | 1 | Type 0 access accepted this cycle |
| t0_write | input | 1 | Type 0 access is a write |
| t0_idx | input | ADDR_W | Type 0 register index |
| t0_wdata | input | DATA_W | Type 0 write data |
| t0_ack | output | 1 | Type 0 access done |
| t0_rdata | output | DATA_W | Type 0 read data |
| cfg_rst_n_o | output | 1 | Configuration-space reset, active low |
| sec_bus_rst_o | output | 1 | Secondary-bus reset request |

## Verification
The bench builds the gate with ADDR_W=4 and DATA_W=8. It places the initialization register at index 15 and the secondary-bus reset control at bit 6 of index 3. With only sixteen registers, it can sweep every index through every pairing of writer and reader port, with data computed from the index. It can also check that retried host writes leave all sixteen registers untouched. The small width leaves room to build the same-cycle cases by hand: the two local ports colliding, the clear racing a host request, a request in the capture cycle, and a strap change after capture.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SB   = 2'd1,
    SRC_T0   = 2'd2,
    SRC_HOST = 2'd3
  } src_e;

  localparam logic [2:0] CPL_SC  = 3'b000;
  localparam logic [2:0] CPL_CRS = 3'b010;
endpackage

// File: rtl/cgr_init.sv
module cgr_init (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  input  logic ip_clr,
  output logic gate_on,
  output logic cfg_rst_n
);
  logic first_q, first_d;
  logic ip_q, ip_d;
  logic crst_q, crst_d;

  // During the capture cycle the strap itself decides the gate
  assign gate_on   = first_q ? strap : ip_q;
  assign cfg_rst_n = crst_q;

  always_comb begin
    first_d = 1'b0;
    ip_d    = gate_on & ~ip_clr;
    crst_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      ip_q    <= 1'b1;
      crst_q  <= 1'b0;
    end else begin
      first_q <= first_d;
      ip_q    <= ip_d;
      crst_q  <= crst_d;
    end
  end
endmodule

// File: rtl/cgr_arb.sv
module cgr_arb
  import cgr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              sb_valid,
  input  logic              sb_write,
  input  logic [ADDR_W-1:0] sb_idx,
  input  logic [DATA_W-1:0] sb_wdata,
  input  logic              t0_valid,
  input  logic              t0_write,
  input  logic [ADDR_W-1:0] t0_idx,
  input  logic [DATA_W-1:0] t0_wdata,
  input  logic              hst_valid,
  input  logic              hst_write,
  input  logic [ADDR_W-1:0] hst_idx,
  input  logic [DATA_W-1:0] hst_wdata,
  output src_e              src,
  output logic              t0_ready,
  output logic              hst_ready,
  output logic              acc_en,
  output logic              acc_write,
  output logic              acc_local,
  output logic [ADDR_W-1:0] acc_idx,
  output logic [DATA_W-1:0] acc_wdata
);
  always_comb begin
    t0_ready  = ~sb_valid;
    hst_ready = ~sb_valid & ~t0_valid;
    src       = SRC_NONE;
    acc_write = 1'b0;
    acc_idx   = hst_idx;
    acc_wdata = hst_wdata;
    if (sb_valid) begin
      src       = SRC_SB;
      acc_write = sb_write;
      acc_idx   = sb_idx;
      acc_wdata = sb_wdata;
    end else if (t0_valid) begin
      src       = SRC_T0;
      acc_write = t0_write;
      acc_idx   = t0_idx;
      acc_wdata = t0_wdata;
    end else if (hst_valid) begin
      src       = SRC_HOST;
      acc_write = hst_write;
    end
    acc_en    = (src != SRC_NONE);
    acc_local = (src == SRC_SB) || (src == SRC_T0);
  end
endmodule

// File: rtl/cgr_regs.sv
module cgr_regs #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int INIT_IDX = 63,
  parameter int IP_BIT   = 0,
  parameter int BCTL_IDX = 15,
  parameter int BCTL_BIT = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic              acc_local,
  input  logic [ADDR_W-1:0] acc_idx,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              ip_now,
  output logic [DATA_W-1:0] rd_data,
  output logic              ip_clr,
  output logic              sec_rst
);
  localparam int              NREG   = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] INIT_A = ADDR_W'(INIT_IDX);

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic              wr_en;
    logic [DATA_W-1:0] reg_d;
    always_comb begin
      wr_en = acc_en & acc_write & (acc_idx == ADDR_W'(g));
      reg_d = acc_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_en) begin
        regs_q[g] <= reg_d;
      end
    end
  end

  always_comb begin
    rd_data = regs_q[acc_idx];
    if (acc_idx == INIT_A) rd_data[IP_BIT] = ip_now;
  end

  // Only a local zero write may clear the in-progress state
  assign ip_clr  = acc_en & acc_write & acc_local & (acc_idx == INIT_A)
                 & ~acc_wdata[IP_BIT];
  assign sec_rst = regs_q[BCTL_IDX][BCTL_BIT];
endmodule

// File: rtl/cfg_retry_gate.sv
module cfg_retry_gate
  import cgr_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 32,
  parameter int INIT_IDX = 63,
  parameter int IP_BIT   = 0,
  parameter int BCTL_IDX = 15,
  parameter int BCTL_BIT = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_cfg_retry,
  input  logic              hst_req_valid,
  output logic              hst_req_ready,
  input  logic              hst_req_write,
  input  logic [ADDR_W-1:0] hst_req_idx,
  input  logic [DATA_W-1:0] hst_req_wdata,
  output logic              hst_cpl_valid,
  output logic [2:0]        hst_cpl_status,
  output logic [DATA_W-1:0] hst_cpl_rdata,
  input  logic              sb_valid,
  input  logic              sb_write,
  input  logic [ADDR_W-1:0] sb_idx,
  input  logic [DATA_W-1:0] sb_wdata,
  output logic              sb_ack,
  output logic [DATA_W-1:0] sb_rdata,
  input  logic              t0_valid,
  output logic              t0_ready,
  input  logic              t0_write,
  input  logic [ADDR_W-1:0] t0_idx,
  input  logic [DATA_W-1:0] t0_wdata,
  output logic              t0_ack,
  output logic [DATA_W-1:0] t0_rdata,
  output logic              cfg_rst_n_o,
  output logic              sec_bus_rst_o
);
  logic              gate_on;
  logic              ip_clr;
  logic              arb_hst_ready;
  src_e              src;
  logic              acc_en, acc_write, acc_local;
  logic [ADDR_W-1:0] acc_idx;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] rd_data;

  cgr_init u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (strap_cfg_retry),
    .ip_clr    (ip_clr),
    .gate_on   (gate_on),
    .cfg_rst_n (cfg_rst_n_o)
  );

  cgr_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .sb_valid  (sb_valid),
    .sb_write  (sb_write),
    .sb_idx    (sb_idx),
    .sb_wdata  (sb_wdata),
    .t0_valid  (t0_valid),
    .t0_write  (t0_write),
    .t0_idx    (t0_idx),
    .t0_wdata  (t0_wdata),
    .hst_valid (hst_req_valid & ~gate_on),
    .hst_write (hst_req_write),
    .hst_idx   (hst_req_idx),
    .hst_wdata (hst_req_wdata),
    .src       (src),
    .t0_ready  (t0_ready),
    .hst_ready (arb_hst_ready),
    .acc_en    (acc_en),
    .acc_write (acc_write),
    .acc_local (acc_local),
    .acc_idx   (acc_idx),
    .acc_wdata (acc_wdata)
  );

  cgr_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_IDX(INIT_IDX), .IP_BIT(IP_BIT),
    .BCTL_IDX(BCTL_IDX), .BCTL_BIT(BCTL_BIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_write (acc_write),
    .acc_local (acc_local),
    .acc_idx   (acc_idx),
    .acc_wdata (acc_wdata),
    .ip_now    (gate_on),
    .rd_data   (rd_data),
    .ip_clr    (ip_clr),
    .sec_rst   (sec_bus_rst_o)
  );

  // Retries never touch the register file, so they are always taken
  assign hst_req_ready = gate_on | arb_hst_ready;

  logic              cpl_v_q, cpl_v_d;
  logic [2:0]        cpl_st_q, cpl_st_d;
  logic [DATA_W-1:0] cpl_rd_q, cpl_rd_d;
  logic              cpl_en;
  logic              sb_ack_q, sb_ack_d, sb_rd_en;
  logic [DATA_W-1:0] sb_rd_q;
  logic              t0_ack_q, t0_ack_d, t0_rd_en;
  logic [DATA_W-1:0] t0_rd_q;

  always_comb begin
    cpl_v_d  = hst_req_valid & hst_req_ready;
    cpl_en   = cpl_v_d;
    cpl_st_d = gate_on ? CPL_CRS : CPL_SC;
    cpl_rd_d = (!gate_on && !hst_req_write) ? rd_data : '0;
    sb_ack_d = (src == SRC_SB);
    sb_rd_en = sb_ack_d & ~acc_write;
    t0_ack_d = (src == SRC_T0);
    t0_rd_en = t0_ack_d & ~acc_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_v_q  <= 1'b0;
      cpl_st_q <= CPL_SC;
      cpl_rd_q <= '0;
      sb_ack_q <= 1'b0;
      sb_rd_q  <= '0;
      t0_ack_q <= 1'b0;
      t0_rd_q  <= '0;
    end else begin
      cpl_v_q  <= cpl_v_d;
      sb_ack_q <= sb_ack_d;
      t0_ack_q <= t0_ack_d;
      if (cpl_en) begin
        cpl_st_q <= cpl_st_d;
        cpl_rd_q <= cpl_rd_d;
      end
      if (sb_rd_en) sb_rd_q <= rd_data;
      if (t0_rd_en) t0_rd_q <= rd_data;
    end
  end

  assign hst_cpl_valid  = cpl_v_q;
  assign hst_cpl_status = cpl_st_q;
  assign hst_cpl_rdata  = cpl_rd_q;
  assign sb_ack         = sb_ack_q;
  assign sb_rdata       = sb_rd_q;
  assign t0_ack         = t0_ack_q;
  assign t0_rdata       = t0_rd_q;
endmodule

// File: rtl/cgr_chk.sv
module cgr_chk
  import cgr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       hst_req_valid,
  input logic       hst_req_ready,
  input logic       hst_cpl_valid,
  input logic [2:0] hst_cpl_status,
  input logic       sb_valid,
  input logic       t0_valid,
  input logic       sb_ack,
  input logic       t0_ack,
  input logic       cfg_rst_n_o,
  input logic       gate_on
);
  p_crs_in_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_req_valid && gate_on) |=> (hst_cpl_valid && hst_cpl_status == CPL_CRS));

  p_sc_after_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_req_valid && hst_req_ready && !gate_on) |=> (hst_cpl_status == CPL_SC));

  p_no_reenter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |=> !gate_on);

  p_sb_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sb_valid |=> sb_ack);

  p_t0_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_valid && t0_valid) |=> !t0_ack);

  p_no_spurious_cpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hst_req_valid && hst_req_ready) |=> !hst_cpl_valid);

  p_cfgrst_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rst_n_o |=> cfg_rst_n_o);
endmodule

bind cfg_retry_gate cgr_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hst_req_valid  (hst_req_valid),
  .hst_req_ready  (hst_req_ready),
  .hst_cpl_valid  (hst_cpl_valid),
  .hst_cpl_status (hst_cpl_status),
  .sb_valid       (sb_valid),
  .t0_valid       (t0_valid),
  .sb_ack         (sb_ack),
  .t0_ack         (t0_ack),
  .cfg_rst_n_o    (cfg_rst_n_o),
  .gate_on        (gate_on)
);

// File: tb/cfg_retry_gate_test.sv
module cfg_retry_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NR = 1 << AW;
  localparam int INIT_I = 15;
  localparam int BCTL_I = 3;
  localparam int BCTL_B = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic hv = 1'b0, hw = 1'b0;
  logic [AW-1:0] hi = '0;
  logic [DW-1:0] hd = '0;
  logic sv = 1'b0, sw = 1'b0;
  logic [AW-1:0] si = '0;
  logic [DW-1:0] sd = '0;
  logic tv = 1'b0, tw = 1'b0;
  logic [AW-1:0] ti = '0;
  logic [DW-1:0] td = '0;
  logic hready, hcv, sack, tready, tack, crst_n, sbr;
  logic [2:0] hst;
  logic [DW-1:0] hrd, srd, trd;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mem [NR];
  logic ip_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_retry_gate #(
    .ADDR_W(AW), .DATA_W(DW), .INIT_IDX(INIT_I), .IP_BIT(0),
    .BCTL_IDX(BCTL_I), .BCTL_BIT(BCTL_B)
  ) uut (
    .clk(clk), .rst_n(rst_n), .strap_cfg_retry(strap),
    .hst_req_valid(hv), .hst_req_ready(hready), .hst_req_write(hw),
    .hst_req_idx(hi), .hst_req_wdata(hd),
    .hst_cpl_valid(hcv), .hst_cpl_status(hst), .hst_cpl_rdata(hrd),
    .sb_valid(sv), .sb_write(sw), .sb_idx(si), .sb_wdata(sd),
    .sb_ack(sack), .sb_rdata(srd),
    .t0_valid(tv), .t0_ready(tready), .t0_write(tw), .t0_idx(ti), .t0_wdata(td),
    .t0_ack(tack), .t0_rdata(trd),
    .cfg_rst_n_o(crst_n), .sec_bus_rst_o(sbr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(input int idx);
    logic [DW-1:0] v;
    v = mem[idx];
    if (idx == INIT_I) v[0] = ip_exp;
    return v;
  endfunction

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    repeat (3) @(negedge clk);
    chk("R8 cfg reset low in reset", crst_n, 0);
    for (int i = 0; i < NR; i++) mem[i] = '0;
    ip_exp = s;
    rst_n = 1'b1;
  endtask

  task automatic sb_acc(input logic w, input int idx, input logic [DW-1:0] d,
                        output logic [DW-1:0] r);
    sv = 1'b1; sw = w; si = AW'(idx); sd = d;
    @(negedge clk);
    sv = 1'b0;
    chk("R5 sideband ack", sack, 1);
    r = srd;
  endtask

  task automatic t0_acc(input logic w, input int idx, input logic [DW-1:0] d,
                        output logic [DW-1:0] r);
    tv = 1'b1; tw = w; ti = AW'(idx); td = d;
    @(negedge clk);
    tv = 1'b0;
    chk("R5 type0 ack", tack, 1);
    r = trd;
  endtask

  task automatic h_acc(input logic w, input int idx, input logic [DW-1:0] d,
                       output logic [2:0] st, output logic [DW-1:0] r);
    hv = 1'b1; hw = w; hi = AW'(idx); hd = d;
    #1;
    chk("R5 host ready when no local", hready, 1);
    @(negedge clk);
    hv = 1'b0;
    chk("R2 host completion valid", hcv, 1);
    st = hst;
    r = hrd;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    logic [2:0] st;
    logic [DW-1:0] da;

    // ---- strap high: setup mode ----
    do_reset(1'b1);
    @(negedge clk);
    chk("R8 cfg reset released", crst_n, 1);
    chk("R9 sec bus reset idle", sbr, 0);
    strap = 1'b0;  // R1: change after capture must not matter

    // R2: every host read is retried with zero data
    for (int i = 0; i < NR; i++) begin
      h_acc(1'b0, i, '0, st, r);
      chk("R2 retry status", st, 3'b010);
      chk("R2 retry data zero", r, 0);
    end
    // R2: retried host writes change nothing
    for (int i = 0; i < NR; i++) begin
      h_acc(1'b1, i, DW'(i * 17 + 3), st, r);
      chk("R2 write retried", st, 3'b010);
    end
    // R10 / R1 / R2: all registers still zero, in-progress bit set
    for (int i = 0; i < NR; i++) begin
      sb_acc(1'b0, i, '0, r);
      chk("R10 reset value", r, exp_rd(i));
    end
    sb_acc(1'b0, INIT_I, '0, r);
    chk("R1 in-progress after strap", r[0], 1);

    // R6: sideband writes, Type 0 reads next cycle, then the reverse
    for (int i = 0; i < NR; i++) begin
      if (i == INIT_I) continue;
      da = DW'(i * 29 + 7);
      if (i == BCTL_I) da[BCTL_B] = 1'b0;
      sb_acc(1'b1, i, da, r);
      mem[i] = da;
      t0_acc(1'b0, i, '0, r);
      chk("R6 sb write seen by t0", r, exp_rd(i));
      da = DW'(i * 53 + 101);
      if (i == BCTL_I) da[BCTL_B] = 1'b0;
      t0_acc(1'b1, i, da, r);
      mem[i] = da;
      sb_acc(1'b0, i, '0, r);
      chk("R6 t0 write seen by sb", r, exp_rd(i));
    end

    // R5: collision, sideband wins, Type 0 waits one cycle
    sv = 1'b1; sw = 1'b1; si = AW'(5); sd = 8'h11;
    tv = 1'b1; tw = 1'b1; ti = AW'(5); td = 8'h22;
    #1;
    chk("R5 t0 blocked by sideband", tready, 0);
    @(negedge clk);
    sv = 1'b0;
    chk("R5 sb served first", sack, 1);
    chk("R5 t0 not served", tack, 0);
    #1;
    chk("R5 t0 ready after sb", tready, 1);
    @(negedge clk);
    tv = 1'b0;
    chk("R5 t0 served second", tack, 1);
    mem[5] = 8'h22;
    sb_acc(1'b0, 5, '0, r);
    chk("R5 later write wins", r, 8'h22);

    // R4: local write of ones keeps the bit set, other bits stored
    sb_acc(1'b1, INIT_I, 8'hFF, r);
    mem[INIT_I] = 8'hFF;
    t0_acc(1'b0, INIT_I, '0, r);
    chk("R4 local write 1 keeps mode", r, 8'hFF);
    h_acc(1'b0, 0, '0, st, r);
    chk("R4 still retrying", st, 3'b010);

    // R7: clear races a host request in the same cycle
    sv = 1'b1; sw = 1'b1; si = AW'(INIT_I); sd = 8'hFE;
    hv = 1'b1; hw = 1'b0; hi = AW'(1);
    #1;
    chk("R7 host taken while gated", hready, 1);
    @(negedge clk);
    sv = 1'b0; hv = 1'b0;
    chk("R7 racing request retried", hst, 3'b010);
    mem[INIT_I] = 8'hFE;
    ip_exp = 1'b0;
    h_acc(1'b0, INIT_I, '0, st, r);
    chk("R7 next request success", st, 3'b000);
    chk("R7 init reg data", r, 8'hFE);
    for (int i = 0; i < NR; i++) begin
      h_acc(1'b0, i, '0, st, r);
      chk("R7 open read status", st, 3'b000);
      chk("R7 open read data", r, exp_rd(i));
    end

    // R4: host write to bit 0 ignored, other bits stored
    h_acc(1'b1, INIT_I, 8'h01, st, r);
    mem[INIT_I] = 8'h00;
    sb_acc(1'b0, INIT_I, '0, r);
    chk("R4 host cannot set bit", r, 8'h00);
    // R4: local cannot set it again
    t0_acc(1'b1, INIT_I, 8'h81, r);
    mem[INIT_I] = 8'h80;
    sb_acc(1'b0, INIT_I, '0, r);
    chk("R4 local cannot set bit", r, 8'h80);
    h_acc(1'b0, 2, '0, st, r);
    chk("R4 mode stays off", st, 3'b000);

    // R5: host waits for a local access once open
    hv = 1'b1; hw = 1'b0; hi = AW'(2);
    tv = 1'b1; tw = 1'b0; ti = AW'(2);
    #1;
    chk("R5 host blocked by t0", hready, 0);
    @(negedge clk);
    tv = 1'b0;
    chk("R5 no host completion", hcv, 0);
    #1;
    chk("R5 host ready after", hready, 1);
    @(negedge clk);
    hv = 1'b0;
    chk("R5 host completes later", hcv, 1);
    chk("R5 host read data", hrd, exp_rd(2));

    // host writes across all indices, sideband reads back
    for (int i = 0; i < NR; i++) begin
      if (i == INIT_I || i == BCTL_I) continue;
      da = DW'(i * 71 + 5);
      h_acc(1'b1, i, da, st, r);
      chk("R7 host write success", st, 3'b000);
      mem[i] = da;
      sb_acc(1'b0, i, '0, r);
      chk("R6 host write seen by sb", r, exp_rd(i));
    end

    // R9: secondary-bus reset leaves configuration intact
    da = mem[BCTL_I];
    da[BCTL_B] = 1'b1;
    sb_acc(1'b1, BCTL_I, da, r);
    mem[BCTL_I] = da;
    chk("R9 sec bus reset out", sbr, 1);
    chk("R9 cfg reset unaffected", crst_n, 1);
    for (int i = 0; i < NR; i++) begin
      t0_acc(1'b0, i, '0, r);
      chk("R9 registers kept", r, exp_rd(i));
    end
    da[BCTL_B] = 1'b0;
    h_acc(1'b1, BCTL_I, da, st, r);
    mem[BCTL_I] = da;
    chk("R9 sec bus reset cleared", sbr, 0);

    // ---- strap low: normal from the capture cycle ----
    @(negedge clk);
    rst_n = 1'b0;
    strap = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 cfg reset low again", crst_n, 0);
    for (int i = 0; i < NR; i++) mem[i] = '0;
    ip_exp = 1'b0;
    hv = 1'b1; hw = 1'b0; hi = AW'(INIT_I);
    rst_n = 1'b1;
    @(negedge clk);
    hv = 1'b0;
    chk("R3 capture-cycle request done", hcv, 1);
    chk("R3 capture-cycle success", hst, 3'b000);
    chk("R3 in-progress bit clear", hrd[0], 0);
    chk("R8 cfg reset released again", crst_n, 1);
    strap = 1'b1;  // R1: late strap must not enter the mode
    for (int i = 0; i < NR; i++) begin
      h_acc(1'b0, i, '0, st, r);
      chk("R1 late strap ignored", st, 3'b000);
      chk("R10 zero after reset", r, exp_rd(i));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule